// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks the singly linked chain of extended capability headers that lives in the upper part of a 4 KB configuration space. It reads one 32-bit header at a time through a synchronous memory read port with one cycle of latency. In find mode it takes a 16-bit capability ID and returns the byte offset of the first header that carries it, or zero when the chain ends without a match, together with the offset of the header visited just before the stop.

In append mode it links a new header onto the chain. When the new offset is the fixed head offset 0x100 it writes the new header only. At any other offset it first walks to the tail, with ID matching switched off so that no stored ID can end the walk early. It then rewrites the tail's next field to point at the new offset and writes the new header with a next field of zero. Offsets that fall outside the legal window, misaligned append offsets and chains that loop forever all end the operation with an error flag.

Top module: `ecap_walker`

## Requirements
- R1: A header word holds the capability ID in bits 15:0, the version in bits 19:16 and the next offset in bits 31:20. Every walk reads the header at byte offset 0x100 first. Memory addresses are byte offsets. Read data appears on `mem_rdata_i` one cycle after `mem_re_o`. Reads and writes never occur in the same cycle.
- R2: If the header at 0x100 reads as all zeros, a find reports offset 0, previous offset 0 and no error.
- R3: When a header's ID equals the requested ID (`mode_i`=0), the walk stops with `found_off_o` set to that header's offset and `prev_off_o` set to the offset of the header visited before it, or 0 if it is the first header.
- R4: When a header with next offset 0 is reached without a match, the result is `found_off_o`=0 and `prev_off_o`= the tail's offset.
- R5: A next offset below 0x100 or above 0xFF8 sets `err_o` and ends the walk without reading that offset. 0xFF8 itself is legal.
- R6: If MAX_HOPS headers have been visited and the chain still continues, the walk ends with `err_o` set.
- R7: An append (`mode_i`=1) with offset 0x100 performs exactly one write, to 0x100, of the word {12'h000, version, ID}.
- R8: An append at any other offset writes the tail's header with its next field replaced by the new offset and its ID and version kept. It then writes the new header {12'h000, version, ID} at the new offset. In append mode an ID match never ends the walk. An append at an offset other than 0x100 onto an empty chain sets `err_o` and writes nothing.
- R9: An append offset whose bits 1:0 are not zero sets `err_o`, and nothing is written.
- R10: `busy_o` is high from the cycle after an accepted start through the done cycle. `done_o` is high for exactly one cycle. `start_i` is ignored while `busy_o` is high.
- R11: After reset `busy_o`, `done_o`, `err_o`, `found_off_o` and `prev_off_o` are zero and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (taken only when idle) |
| mode_i | input | 1 | 0 = find, 1 = append |
| cap_id_i | input | 16 | Capability ID to find or to write |
| cap_ver_i | input | 4 | Version written in append mode |
| new_off_i | input | 12 | Byte offset of the header to append |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_off_o | output | 12 | Offset of the matching header, or 0 |
| prev_off_o | output | 12 | Offset of the header before the stop, or 0 |
| err_o | output | 1 | Range, alignment, empty-append or hop-limit error |
| mem_re_o | output | 1 | Memory read request |
| mem_we_o | output | 1 | Memory write request |
| mem_addr_o | output | 12 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the request |

## Verification
The bound checker holds four properties on every cycle. Reads never leave the 0x100 to 0xFF8 window, writes are word aligned, read and write never share a cycle, and no access happens while idle. It also checks the start/busy/done handshake. Whether a walk returns the right offsets, whether the tail is relinked with its other fields intact, and whether a looping chain is caught depend on the chain laid out in memory. Only the bench's prepared chains show these behaviours, and it checks them by inspecting the results and the memory contents afterwards.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int OFF_W  = 12;
  localparam int ID_W   = 16;
  localparam int VER_W  = 4;
  localparam int DATA_W = OFF_W + VER_W + ID_W;

  localparam logic [OFF_W-1:0] LIST_HEAD = 12'h100;
  localparam logic [OFF_W-1:0] LIST_LAST = 12'hFF8;

  typedef struct packed {
    logic [OFF_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_LINK,
    ST_NEW,
    ST_DONE
  } state_e;
endpackage

// File: rtl/ecap_off_chk.sv
module ecap_off_chk
  import ecap_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  output logic             in_range_o,
  output logic             aligned_o
);
  assign in_range_o = (off_i >= LIST_HEAD) && (off_i <= LIST_LAST);
  assign aligned_o  = (off_i[1:0] == 2'b00);
endmodule

// File: rtl/ecap_hop_ctr.sv
module ecap_hop_ctr #(
  parameter int MAX_HOPS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(MAX_HOPS + 1);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_HOPS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // current header is the last one allowed
  assign last_o = (cnt_q == LAST_VAL);
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
  import ecap_pkg::*;
#(
  parameter int MAX_HOPS = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [ID_W-1:0]   cap_id_i,
  input  logic [VER_W-1:0]  cap_ver_i,
  input  logic [OFF_W-1:0]  new_off_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [OFF_W-1:0]  found_off_o,
  output logic [OFF_W-1:0]  prev_off_o,
  output logic              err_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [OFF_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  state_e           state_q;
  logic [OFF_W-1:0] cur_q, walk_prev_q, new_off_q, found_q, res_prev_q;
  logic [ID_W-1:0]  id_q;
  logic [VER_W-1:0] ver_q;
  logic             append_q, err_q;
  hdr_t             tail_q;

  hdr_t rd_hdr;
  logic nxt_in_range, nxt_aligned_unused;
  logic new_in_range_unused, new_aligned;
  logic hop_last, hop_clr, hop_inc;

  assign rd_hdr = hdr_t'(mem_rdata_i);

  ecap_off_chk u_nxt_chk (
    .off_i      (rd_hdr.nxt),
    .in_range_o (nxt_in_range),
    .aligned_o  (nxt_aligned_unused)
  );

  ecap_off_chk u_new_chk (
    .off_i      (new_off_i),
    .in_range_o (new_in_range_unused),
    .aligned_o  (new_aligned)
  );

  assign hop_clr = (state_q == ST_IDLE);
  assign hop_inc = (state_q == ST_EVAL);

  ecap_hop_ctr #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (hop_clr),
    .inc_i  (hop_inc),
    .last_o (hop_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      walk_prev_q <= '0;
      new_off_q   <= '0;
      found_q     <= '0;
      res_prev_q  <= '0;
      id_q        <= '0;
      ver_q       <= '0;
      append_q    <= 1'b0;
      err_q       <= 1'b0;
      tail_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          id_q        <= cap_id_i;
          ver_q       <= cap_ver_i;
          new_off_q   <= new_off_i;
          append_q    <= mode_i;
          found_q     <= '0;
          res_prev_q  <= '0;
          err_q       <= 1'b0;
          cur_q       <= LIST_HEAD;
          walk_prev_q <= '0;
          if (mode_i && !new_aligned) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (mode_i && new_off_i == LIST_HEAD) begin
            state_q <= ST_NEW;
          end else begin
            state_q <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_EVAL;
        ST_EVAL: begin
          if (cur_q == LIST_HEAD && mem_rdata_i == '0) begin
            err_q   <= append_q;  // nothing to link onto
            state_q <= ST_DONE;
          end else if (!append_q && rd_hdr.id == id_q) begin
            found_q    <= cur_q;
            res_prev_q <= walk_prev_q;
            state_q    <= ST_DONE;
          end else if (rd_hdr.nxt == '0) begin
            res_prev_q <= cur_q;
            tail_q     <= rd_hdr;
            state_q    <= append_q ? ST_LINK : ST_DONE;
          end else if (!nxt_in_range || hop_last) begin
            res_prev_q <= cur_q;
            err_q      <= 1'b1;
            state_q    <= ST_DONE;
          end else begin
            walk_prev_q <= cur_q;
            cur_q       <= rd_hdr.nxt;
            state_q     <= ST_READ;
          end
        end
        ST_LINK: state_q <= ST_NEW;
        ST_NEW:  state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_re_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_READ: begin
        mem_re_o   = 1'b1;
        mem_addr_o = cur_q;
      end
      ST_LINK: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = res_prev_q;
        mem_wdata_o = {new_off_q, tail_q.ver, tail_q.id};
      end
      ST_NEW: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = new_off_q;
        mem_wdata_o = {{OFF_W{1'b0}}, ver_q, id_q};
      end
      default: ;
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign found_off_o = found_q;
  assign prev_off_o  = res_prev_q;
  assign err_o       = err_q;
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk
  import ecap_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             mem_re_o,
  input logic             mem_we_o,
  input logic [OFF_W-1:0] mem_addr_o
);
  assert_read_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> (mem_addr_o >= LIST_HEAD && mem_addr_o <= LIST_LAST));

  assert_write_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[1:0] == 2'b00));

  assert_single_access_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_re_o && !mem_we_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_in_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_busy_needs_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_done_ends_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

bind ecap_walker ecap_walker_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_re_o   (mem_re_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/sim_ecap_walker.sv
`timescale 1ns/1ps
module sim_ecap_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] cap_id_i = '0;
  logic [3:0]  cap_ver_i = '0;
  logic [11:0] new_off_i = '0;
  logic        busy_o, done_o, err_o, mem_re_o, mem_we_o;
  logic [11:0] found_off_o, prev_off_o, mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i;

  always #4 clk_i = ~clk_i;

  ecap_walker u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .cap_id_i(cap_id_i), .cap_ver_i(cap_ver_i), .new_off_i(new_off_i),
    .busy_o(busy_o), .done_o(done_o), .found_off_o(found_off_o),
    .prev_off_o(prev_off_o), .err_o(err_o), .mem_re_o(mem_re_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  // bench memory, 1024 words; bench pokes go through the same process
  logic [31:0] mem [1024];
  logic        tb_we = 1'b0, tb_clr = 1'b0;
  logic [9:0]  tb_idx = '0;
  logic [31:0] tb_dat = '0;
  int          writes = 0;

  always_ff @(posedge clk_i) begin
    if (tb_clr) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
    end else if (tb_we) begin
      mem[tb_idx] <= tb_dat;
    end else if (mem_we_o) begin
      mem[mem_addr_o[11:2]] <= mem_wdata_o;
    end
    if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[11:2]];
    if (mem_we_o) writes <= writes + 1;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] v,
                                      input logic [11:0] nxt);
    return {nxt, v, id};
  endfunction

  task automatic poke(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk_i);
    tb_we = 1'b1; tb_idx = off[11:2]; tb_dat = d;
    @(negedge clk_i);
    tb_we = 1'b0;
  endtask

  task automatic wipe();
    @(negedge clk_i);
    tb_clr = 1'b1;
    @(negedge clk_i);
    tb_clr = 1'b0;
  endtask

  // standard chain: 0x100 -> 0x140 -> 0x200 -> end
  task automatic build_chain();
    wipe();
    poke(12'h100, hdr(16'h0001, 4'h1, 12'h140));
    poke(12'h140, hdr(16'h000B, 4'h2, 12'h200));
    poke(12'h200, hdr(16'h0010, 4'h1, 12'h000));
  endtask

  logic [11:0] r_found, r_prev;
  logic        r_err;
  bit          r_to;

  task automatic run(input logic md, input logic [15:0] id, input logic [3:0] v,
                     input logic [11:0] off);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = md; cap_id_i = id; cap_ver_i = v; new_off_i = off;
    @(negedge clk_i);
    start_i = 1'b0;
    r_to = 1'b1;
    for (int n = 0; n < 6000; n++) begin
      if (done_o) begin r_to = 1'b0; break; end
      @(negedge clk_i);
    end
    r_found = found_off_o; r_prev = prev_off_o; r_err = err_o;
    chk(!r_to, "R10 done reached", int'(r_to), 0);
  endtask

  // {id, expected found, expected prev}
  localparam int NV = 5;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0001, 12'h100, 12'h000},
    {16'h000B, 12'h140, 12'h100},
    {16'h0010, 12'h200, 12'h140},
    {16'h1234, 12'h000, 12'h200},
    {16'h0000, 12'h000, 12'h200}
  };

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk(!busy_o && !done_o && !err_o, "R11 flags", {busy_o, done_o, err_o}, 0);
    chk(found_off_o == 0 && prev_off_o == 0, "R11 offsets", found_off_o, 0);
    chk(!mem_re_o && !mem_we_o, "R11 no access", {mem_re_o, mem_we_o}, 0);
    rst_ni = 1'b1;

    build_chain();
    for (int k = 0; k < NV; k++) begin
      run(1'b0, VEC[k][39:24], 4'h0, 12'h000);
      chk(r_found == VEC[k][23:12], (VEC[k][23:12] != 0) ? "R3 found" : "R4 found",
          r_found, VEC[k][23:12]);
      chk(r_prev == VEC[k][11:0], (VEC[k][23:12] != 0) ? "R3 prev" : "R4 prev",
          r_prev, VEC[k][11:0]);
      chk(!r_err, "R1 no err", r_err, 0);
    end

    // R2: empty chain
    wipe();
    run(1'b0, 16'h0001, 4'h0, 12'h000);
    chk(r_found == 0 && r_prev == 0 && !r_err, "R2 empty", {r_found, r_prev, r_err}, 0);

    // R5: next below 0x100
    wipe();
    poke(12'h100, hdr(16'h0001, 4'h1, 12'h0F0));
    run(1'b0, 16'h0022, 4'h0, 12'h000);
    chk(r_err, "R5 low next", r_err, 1);
    // R5: next above 0xFF8
    poke(12'h100, hdr(16'h0001, 4'h1, 12'hFFC));
    run(1'b0, 16'h0022, 4'h0, 12'h000);
    chk(r_err, "R5 high next", r_err, 1);
    // R5: 0xFF8 is legal
    poke(12'h100, hdr(16'h0001, 4'h1, 12'hFF8));
    poke(12'hFF8, hdr(16'h0022, 4'h1, 12'h000));
    run(1'b0, 16'h0022, 4'h0, 12'h000);
    chk(!r_err && r_found == 12'hFF8 && r_prev == 12'h100, "R5 edge FF8",
        r_found, 12'hFF8);

    // R6: cyclic chain
    wipe();
    poke(12'h100, hdr(16'h0001, 4'h1, 12'h140));
    poke(12'h140, hdr(16'h0002, 4'h1, 12'h100));
    run(1'b0, 16'h0033, 4'h0, 12'h000);
    chk(r_err && r_found == 0, "R6 hop limit", r_err, 1);

    // R7: append at head onto empty chain
    wipe();
    w0 = writes;
    run(1'b1, 16'h00AA, 4'h3, 12'h100);
    @(negedge clk_i);
    chk(!r_err, "R7 no err", r_err, 0);
    chk(mem[12'h100 >> 2] == hdr(16'h00AA, 4'h3, 12'h000), "R7 header",
        mem[12'h100 >> 2], hdr(16'h00AA, 4'h3, 12'h000));
    chk(writes - w0 == 1, "R7 one write", writes - w0, 1);

    // R8: append at 0x300 onto chain; ID 0x0001 present must not stop walk
    build_chain();
    run(1'b1, 16'h0001, 4'h5, 12'h300);
    @(negedge clk_i);
    chk(!r_err && r_prev == 12'h200, "R8 tail", r_prev, 12'h200);
    chk(mem[12'h200 >> 2] == hdr(16'h0010, 4'h1, 12'h300), "R8 relink",
        mem[12'h200 >> 2], hdr(16'h0010, 4'h1, 12'h300));
    chk(mem[12'h300 >> 2] == hdr(16'h0001, 4'h5, 12'h000), "R8 new hdr",
        mem[12'h300 >> 2], hdr(16'h0001, 4'h5, 12'h000));
    run(1'b0, 16'hBEEF, 4'h0, 12'h000);
    chk(r_prev == 12'h300 && r_found == 0, "R8 new tail", r_prev, 12'h300);

    // R8: append elsewhere onto empty chain
    wipe();
    w0 = writes;
    run(1'b1, 16'h0004, 4'h1, 12'h180);
    @(negedge clk_i);
    chk(r_err && writes == w0, "R8 empty append", writes - w0, 0);

    // R9: misaligned append
    build_chain();
    w0 = writes;
    run(1'b1, 16'h0007, 4'h1, 12'h302);
    @(negedge clk_i);
    chk(r_err && writes == w0, "R9 misaligned", writes - w0, 0);
    chk(mem[12'h200 >> 2] == hdr(16'h0010, 4'h1, 12'h000), "R9 tail kept",
        mem[12'h200 >> 2], hdr(16'h0010, 4'h1, 12'h000));

    // R10: start while busy is ignored
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 1'b0; cap_id_i = 16'h0010;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R10 busy", busy_o, 1);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 1'b1; cap_id_i = 16'h0009; new_off_i = 12'h400;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n < 100 && !done_o; n++) @(negedge clk_i);
    chk(found_off_o == 12'h200 && prev_off_o == 12'h140, "R10 first op kept",
        found_off_o, 12'h200);
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R10 done one cycle", {busy_o, done_o}, 0);
    repeat (10) @(negedge clk_i);
    chk(mem[12'h400 >> 2] == 0, "R10 ignored append", mem[12'h400 >> 2], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule